// File: doc/BRIEF.md
# STEP/DIR Microstepping Indexer

This block turns a STEP/DIR command stream into the pair of signed relative current set-points that a two-winding bipolar stepper needs. It holds a 7-bit electrical position that covers one full electrical revolution in 128 equal steps of 360/128 degrees. Winding A follows the cosine of the angle and winding B the sine, both scaled so that 255 is full current. Each qualified rising edge of STEP moves the position by a stride picked by a 3-bit resolution input, from 32 entries (full step) down to 1 entry (1/32 step). DIR picks forward or reverse travel.

The position starts at, and returns to, the 45° home entry, where both windings carry about 71% current. When the resolution changes between steps, the next step lands on the nearest state that is legal for the new resolution in the direction of travel, not on a plain stride from the old position. Each winding also has a flag that tells the current chopper whether the last step lowered that winding's magnitude. The flag is used to choose between mixed decay and slow decay.

STEP may be asynchronous. It passes through a two-flop synchronizer, and its rising edge is detected on the system clock. The home and enable inputs are synchronous to that clock.

Top module: `stepidx_top`

## Requirements
- R1: While rst_n or home_n is low, the position is set to the home entry 16 (45°): both current outputs read +180 and both decreasing flags read 0.
- R2: mode_in selects the stride in table entries: 000 gives 32, 001 gives 16, 010 gives 8, 011 gives 4, 100 gives 2, and 101, 110 and 111 each give 1. The position wraps modulo 128.
- R3: In full-step mode (000) the position only visits entries 16, 48, 80 and 112. At each of these both outputs have magnitude 180.
- R4: With dir_in high a step adds the stride, so the angle increases. With dir_in low it subtracts the stride.
- R5: At entry p, win_a_cur = round(255·cos(2πp/128)) and win_b_cur = round(255·sin(2πp/128)), each as a 9-bit two's-complement value. A positive value means output 1 of the winding is driven positive relative to output 2.
- R6: A step always lands on the next valid entry of the current mode in the direction of travel, even when the present entry is not valid for that mode. Valid entries are those with p mod 32 = 16 in full-step mode, and multiples of the stride in every other mode.
- R7: A STEP rising edge that is detected while enable is low or home_n is low has no effect, and it is not acted on later.
- R8: A rising edge on step_in changes the outputs on the third rising clock edge after it arrives. A single STEP pulse gives exactly one step, however long it stays high.
- R9: After each step, win_x_dec is 1 exactly when the new magnitude of winding x is smaller than its magnitude before the step. The flags hold until the next step or home.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; forces home |
| home_n | input | 1 | Synchronous active-low indexer home; forces home and blocks steps |
| enable | input | 1 | High to accept STEP edges |
| step_in | input | 1 | Step command, may be asynchronous; acts on rising edge |
| dir_in | input | 1 | 1 = forward (increasing angle), 0 = reverse |
| mode_in | input | 3 | Step resolution select |
| win_a_cur | output | 9 | Signed relative current for winding A (cosine) |
| win_b_cur | output | 9 | Signed relative current for winding B (sine) |
| win_a_dec | output | 1 | Winding A magnitude fell on the last step |
| win_b_dec | output | 1 | Winding B magnitude fell on the last step |

## Verification
Several rules are checked by assertions on every cycle:
- home forcing and flag clearing;
- the position holding whenever no qualified edge is seen;
- full-step landings on the diagonal entries;
- the ±1 stride at the finest resolution;
- equal winding magnitudes at the diagonal entries.

Other behaviour is shown only by the bench's sweeps:
- the exact cosine and sine values at every entry, in every mode and in both directions;
- realignment after a mode change from an off-grid position;
- the three-edge synchronizer latency;
- the fact that an edge masked by enable is lost and not replayed.

// File: rtl/stepidx_pkg.sv
// Shared sizes, types and helpers for the STEP/DIR indexer.
// Assumes a 128-entry electrical cycle held as a quarter-wave table.
package stepidx_pkg;
    localparam int POS_W     = 7;                 // bits of electrical position
    localparam int QTR_W     = POS_W - 2;         // bits inside one quadrant
    localparam int QTR_N     = 1 << QTR_W;        // entries per quadrant
    localparam int MAG_W     = 8;                 // magnitude width
    localparam int CUR_W     = MAG_W + 1;         // signed current width
    localparam int MODE_W    = 3;
    localparam int MAX_SHIFT = QTR_W;             // full step = one quadrant
    localparam int HOME_POS  = QTR_N / 2;         // 45 degrees
    localparam int SYNC_STG  = 2;

    typedef logic [POS_W-1:0]        pos_t;
    typedef logic [MAG_W-1:0]        mag_t;
    typedef logic signed [CUR_W-1:0] cur_t;
    typedef logic [MODE_W-1:0]       mode_t;
    typedef logic [2:0]              shift_t;

    // Log2 of the stride for a resolution code; codes past 1/32 saturate.
    function automatic shift_t mode_shift(input mode_t m);
        if (m >= mode_t'(MAX_SHIFT))
            return shift_t'(0);
        else
            return shift_t'(shift_t'(MAX_SHIFT) - shift_t'(m));
    endfunction
endpackage

// File: rtl/stepidx_edge_sync.sv
// Synchronizer and rising-edge detector for the asynchronous STEP input.
// Assumes STEP high and low times each exceed two clock periods.
module stepidx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    // One-cycle pulse when the synchronized level goes from low to high.
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/stepidx_next_pos.sv
// Combinational next-position calculator.
// Snaps to the grid of the selected resolution, then moves one stride.
// Assumes the full-step grid is offset by half a quadrant (45 degrees).
module stepidx_next_pos
    import stepidx_pkg::*;
(
    input  pos_t  cur_pos,
    input  mode_t mode,
    input  logic  dir_fwd,
    output pos_t  nxt_pos
);
    shift_t sh;
    pos_t   stride;
    pos_t   mask;
    pos_t   offs;
    pos_t   rel;
    pos_t   floor_rel;
    logic   aligned;
    pos_t   fwd_pos;
    pos_t   rev_pos;

    // Derive the stride, the grid offset and the rounded-down grid point.
    always_comb begin
        sh        = mode_shift(mode);
        stride    = pos_t'(1) << sh;
        mask      = ~(stride - pos_t'(1));
        offs      = (sh == shift_t'(MAX_SHIFT)) ? pos_t'(HOME_POS) : pos_t'(0);
        rel       = cur_pos - offs;
        floor_rel = rel & mask;
        aligned   = (rel == floor_rel);
    end

    // Forward always goes one stride past the floor; reverse stops at the
    // floor unless the position is already on the grid.
    always_comb begin
        fwd_pos = floor_rel + stride + offs;
        rev_pos = aligned ? (floor_rel - stride + offs) : (floor_rel + offs);
        nxt_pos = dir_fwd ? fwd_pos : rev_pos;
    end
endmodule

// File: rtl/stepidx_quarter_lut.sv
// Quarter-wave sine magnitude table: entry k = round(255*sin(k*pi/64)).
// Assumes 33 entries (0 to 90 degrees inclusive).
module stepidx_quarter_lut
    import stepidx_pkg::*;
(
    input  logic [QTR_W:0] idx,
    output mag_t           mag
);
    // Constant lookup of the first quadrant.
    always_comb begin
        case (idx)
            6'd0:  mag = 8'd0;
            6'd1:  mag = 8'd13;
            6'd2:  mag = 8'd25;
            6'd3:  mag = 8'd37;
            6'd4:  mag = 8'd50;
            6'd5:  mag = 8'd62;
            6'd6:  mag = 8'd74;
            6'd7:  mag = 8'd86;
            6'd8:  mag = 8'd98;
            6'd9:  mag = 8'd109;
            6'd10: mag = 8'd120;
            6'd11: mag = 8'd131;
            6'd12: mag = 8'd142;
            6'd13: mag = 8'd152;
            6'd14: mag = 8'd162;
            6'd15: mag = 8'd171;
            6'd16: mag = 8'd180;
            6'd17: mag = 8'd189;
            6'd18: mag = 8'd197;
            6'd19: mag = 8'd205;
            6'd20: mag = 8'd212;
            6'd21: mag = 8'd219;
            6'd22: mag = 8'd225;
            6'd23: mag = 8'd231;
            6'd24: mag = 8'd236;
            6'd25: mag = 8'd240;
            6'd26: mag = 8'd244;
            6'd27: mag = 8'd247;
            6'd28: mag = 8'd250;
            6'd29: mag = 8'd252;
            6'd30: mag = 8'd254;
            6'd31: mag = 8'd255;
            6'd32: mag = 8'd255;
            default: mag = 8'd0;
        endcase
    end
endmodule

// File: rtl/stepidx_winding.sv
// One winding's signed current from the electrical position.
// PHASE adds a fixed angle: 0 gives sine, QTR_N gives cosine.
// Uses quadrant mirroring and sign on the quarter-wave table.
module stepidx_winding
    import stepidx_pkg::*;
#(
    parameter int PHASE = 0
) (
    input  pos_t pos,
    output cur_t cur,
    output mag_t mag
);
    pos_t            shifted;
    logic [1:0]      quad;
    logic [QTR_W-1:0] rem;
    logic [QTR_W:0]  idx;
    logic            neg;
    cur_t            mag_ext;

    // Fold the shifted angle into the first quadrant.
    always_comb begin
        shifted = pos + pos_t'(PHASE);
        quad    = shifted[POS_W-1:POS_W-2];
        rem     = shifted[QTR_W-1:0];
        idx     = quad[0] ? ((QTR_W+1)'(QTR_N) - {1'b0, rem}) : {1'b0, rem};
        neg     = quad[1];
    end

    stepidx_quarter_lut u_lut (
        .idx (idx),
        .mag (mag)
    );

    // Apply the half-cycle sign to the magnitude.
    always_comb begin
        mag_ext = cur_t'({1'b0, mag});
        cur     = neg ? -mag_ext : mag_ext;
    end
endmodule

// File: rtl/stepidx_top.sv
// STEP/DIR microstepping indexer top.
// Holds the electrical position, applies qualified STEP edges, and produces
// signed winding currents plus per-winding "magnitude fell" flags.
// Assumes home_n, enable, dir_in and mode_in are synchronous to clk and
// stable around the synchronized STEP edge.
module stepidx_top
    import stepidx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    home_n,
    input  logic                    enable,
    input  logic                    step_in,
    input  logic                    dir_in,
    input  logic [MODE_W-1:0]       mode_in,
    output logic signed [CUR_W-1:0] win_a_cur,
    output logic signed [CUR_W-1:0] win_b_cur,
    output logic                    win_a_dec,
    output logic                    win_b_dec
);
    logic step_rise;
    pos_t pos_q;
    pos_t pos_nxt;
    logic [1:0] dec_q;
    cur_t cur_now [2];
    mag_t mag_now [2];
    cur_t cur_nxt [2];
    mag_t mag_nxt [2];

    stepidx_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (step_in),
        .rise_o   (step_rise)
    );

    stepidx_next_pos u_next (
        .cur_pos (pos_q),
        .mode    (mode_in),
        .dir_fwd (dir_in),
        .nxt_pos (pos_nxt)
    );

    // Winding 0 is A (cosine, +90 degrees), winding 1 is B (sine).
    for (genvar w = 0; w < 2; w++) begin : g_wind
        localparam int PH = (w == 0) ? QTR_N : 0;

        stepidx_winding #(.PHASE(PH)) u_now (
            .pos (pos_q),
            .cur (cur_now[w]),
            .mag (mag_now[w])
        );

        stepidx_winding #(.PHASE(PH)) u_nxt (
            .pos (pos_nxt),
            .cur (cur_nxt[w]),
            .mag (mag_nxt[w])
        );
    end

    // Position and trend flags: home on reset, advance on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !home_n) begin
            pos_q <= pos_t'(HOME_POS);
            dec_q <= '0;
        end else if (enable && step_rise) begin
            pos_q <= pos_nxt;
            for (int w = 0; w < 2; w++)
                dec_q[w] <= (mag_nxt[w] < mag_now[w]);
        end
    end

    assign win_a_cur = cur_now[0];
    assign win_b_cur = cur_now[1];
    assign win_a_dec = dec_q[0];
    assign win_b_dec = dec_q[1];
endmodule

// File: rtl/stepidx_checker.sv
// Property checker for stepidx_top, attached by bind.
module stepidx_checker
    import stepidx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        home_n,
    input logic        enable,
    input logic        dir_in,
    input logic [2:0]  mode_in,
    input logic        step_rise,
    input logic [6:0]  pos_q,
    input logic signed [8:0] win_a_cur,
    input logic signed [8:0] win_b_cur,
    input logic        win_a_dec,
    input logic        win_b_dec
);
    logic qual;
    logic [8:0] abs_a;
    logic [8:0] abs_b;

    // Qualified step and absolute magnitudes for the properties.
    always_comb begin
        qual  = home_n && enable && step_rise;
        abs_a = win_a_cur[8] ? 9'(-win_a_cur) : 9'(win_a_cur);
        abs_b = win_b_cur[8] ? 9'(-win_b_cur) : 9'(win_b_cur);
    end

    AST_HOME_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !home_n |=> (pos_q == 7'(HOME_POS))); // R1

    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !home_n |=> (!win_a_dec && !win_b_dec)); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (home_n && !qual) |=> $stable(pos_q)); // R7

    AST_FULL_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && mode_in == 3'd0) |=> (pos_q[QTR_W-1:0] == 5'(HOME_POS))); // R3

    AST_FINE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && mode_in >= 3'd5 && dir_in) |=> (pos_q == 7'($past(pos_q) + 7'd1))); // R2

    AST_FINE_REV: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && mode_in >= 3'd5 && !dir_in) |=> (pos_q == 7'($past(pos_q) - 7'd1))); // R4

    AST_DIAG_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q[QTR_W-1:0] == 5'(HOME_POS)) |-> (abs_a == abs_b && abs_a == 9'd180)); // R5
endmodule

bind stepidx_top stepidx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .home_n    (home_n),
    .enable    (enable),
    .dir_in    (dir_in),
    .mode_in   (mode_in),
    .step_rise (step_rise),
    .pos_q     (pos_q),
    .win_a_cur (win_a_cur),
    .win_b_cur (win_b_cur),
    .win_a_dec (win_a_dec),
    .win_b_dec (win_b_dec)
);

// File: tb/stepidx_top_bench.sv
// Sweep bench for stepidx_top: every mode, both directions, realignment,
// masking, latency. Expected currents come from real-valued cos/sin.
module stepidx_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic home_n = 1'b1;
    logic enable = 1'b1;
    logic step_in = 1'b0;
    logic dir_in = 1'b1;
    logic [2:0] mode_in = 3'd0;
    logic signed [8:0] win_a_cur;
    logic signed [8:0] win_b_cur;
    logic win_a_dec;
    logic win_b_dec;

    int checks = 0;
    int failures = 0;
    int exp_pos = 16;
    bit exp_da = 0;
    bit exp_db = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stepidx_top u_stepidx_top (
        .clk(clk), .rst_n(rst_n), .home_n(home_n), .enable(enable),
        .step_in(step_in), .dir_in(dir_in), .mode_in(mode_in),
        .win_a_cur(win_a_cur), .win_b_cur(win_b_cur),
        .win_a_dec(win_a_dec), .win_b_dec(win_b_dec)
    );

    function automatic int stride_of(input int m);
        if (m >= 5) return 1;
        return 32 >> m;
    endfunction

    function automatic bit is_valid(input int p, input int m);
        if (m == 0) return (p % 32) == 16;
        return (p % stride_of(m)) == 0;
    endfunction

    // Rounded current for entry p; cosine for A, sine for B.
    function automatic int ideal(input int p, input bit use_cos);
        real th, v;
        int mag;
        th  = 2.0 * 3.14159265358979 * p / 128.0;
        v   = use_cos ? $cos(th) : $sin(th);
        mag = $rtoi((v < 0.0 ? -v : v) * 255.0 + 0.5);
        return (v < 0.0) ? -mag : mag;
    endfunction

    function automatic int iabs(input int v);
        return v < 0 ? -v : v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (pos %0d)", req, act, exp, exp_pos);
        end
    endtask

    task automatic check_outputs(input string req);
        chk(req, int'(win_a_cur), ideal(exp_pos, 1'b1));
        chk(req, int'(win_b_cur), ideal(exp_pos, 1'b0));
        chk({req, "/R9"}, int'(win_a_dec), int'(exp_da));
        chk({req, "/R9"}, int'(win_b_dec), int'(exp_db));
    endtask

    // Model: search the next valid entry one table step at a time.
    task automatic model_step();
        int p;
        int oa, ob;
        oa = iabs(ideal(exp_pos, 1'b1));
        ob = iabs(ideal(exp_pos, 1'b0));
        p  = exp_pos;
        do p = dir_in ? (p + 1) % 128 : (p + 127) % 128;
        while (!is_valid(p, int'(mode_in)));
        exp_pos = p;
        exp_da  = iabs(ideal(p, 1'b1)) < oa;
        exp_db  = iabs(ideal(p, 1'b0)) < ob;
    endtask

    task automatic pulse(input int hi_cycles);
        @(negedge clk) step_in = 1'b1;
        repeat (hi_cycles) @(negedge clk);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic step_and_check(input string req);
        pulse(4);
        if (enable && home_n) model_step();
        check_outputs(req);
    endtask

    task automatic go_home();
        @(negedge clk) home_n = 1'b0;
        @(negedge clk) home_n = 1'b1;
        exp_pos = 16; exp_da = 0; exp_db = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 reset");

        // Sweep each resolution code forward and back (R2 R3 R4 R5 R10 wrap).
        for (int m = 0; m < 8; m++) begin
            mode_in = 3'(m);
            for (int d = 1; d >= 0; d--) begin
                dir_in = d[0];
                for (int k = 0; k <= 128 / stride_of(m); k++)
                    step_and_check(m == 0 ? "R3" : (d == 1 ? "R2" : "R4"));
            end
        end

        // R6: realign from off-grid positions after a mode change.
        go_home();
        mode_in = 3'd5; dir_in = 1'b1;
        repeat (3) step_and_check("R6");
        chk("R6 model", exp_pos, 19);
        mode_in = 3'd2; step_and_check("R6");
        chk("R6 model", exp_pos, 24);
        mode_in = 3'd0; step_and_check("R6");
        mode_in = 3'd5; dir_in = 1'b0; step_and_check("R6");
        mode_in = 3'd0; step_and_check("R6");
        mode_in = 3'd1; step_and_check("R6");
        mode_in = 3'd6; step_and_check("R6");
        mode_in = 3'd3; step_and_check("R6");

        // R7: masked edges are lost, also after re-enabling.
        mode_in = 3'd5; dir_in = 1'b1;
        enable = 1'b0; step_and_check("R7 disabled");
        enable = 1'b1;
        repeat (8) @(negedge clk);
        check_outputs("R7 reenabled");
        step_and_check("R7 live");
        @(negedge clk) home_n = 1'b0;
        step_in = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
        exp_pos = 16; exp_da = 0; exp_db = 0;
        check_outputs("R1 home held");
        home_n = 1'b1;
        repeat (4) @(negedge clk);
        check_outputs("R7 home masked");

        // R8: latency of three clock edges and one step per long pulse.
        @(negedge clk) step_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_outputs("R8 before");
        @(negedge clk);
        model_step();
        check_outputs("R8 third edge");
        repeat (20) @(negedge clk);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
        check_outputs("R8 long pulse");

        // R1: synchronous reset mid-run.
        step_and_check("R1 pre");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        exp_pos = 16; exp_da = 0; exp_db = 0;
        @(negedge clk);
        check_outputs("R1 rst");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule